// File: doc/BRIEF.md
# Ringing-to-Talk Break-Before-Make Sequencer

This block is a host-side controller that moves a telephone line from the ringing state to the talk state. It opens every switch before any break switch can close again. It controls a shutdown line that is wired as open-drain: the block only produces an enable that pulls the line low, and an external pull-up is the only thing that ever makes the line high. It also owns the ringing command bit that the line switch device reads.

The host first raises the ringing command with a one-cycle set pulse. When ringing must end, the host pulses a start request together with the ringing period, counted in clock cycles. The block then runs four steps:

1. It pulls the shutdown line low.
2. One clock later, while the line is still held low, it clears the ringing command.
3. It keeps the line low for at least half of the ringing period, so that the ringing switch can open at a zero-current point.
4. It releases the line, and the pull-up then enables the break switches.

Busy is high for the whole sequence. Done pulses for one cycle after the release.

Top module: `bbm_rtt_seq`

## Requirements
- R1: While reset is active, and for the cycles in which the reset is being released, shdn_pull_o, ring_cmd_o, busy_o and done_o are all 0.
- R2: A ring_set_i pulse while idle, with no start request in the same cycle, makes ring_cmd_o equal to 1 from the next cycle on.
- R3: A start_i pulse while idle makes shdn_pull_o and busy_o equal to 1 from the next cycle on.
- R4: shdn_pull_o stays 1 for exactly L+1 consecutive cycles, where L = max(floor(P/2), 1) and P is the ring_period_i value sampled with the start request.
- R5: ring_cmd_o is 0 from the second cycle of the pull window onward. When it was 1 before the start, it falls exactly one cycle after shdn_pull_o rises.
- R6: In the first cycle after shdn_pull_o falls, done_o is 1 for exactly one cycle and busy_o is still 1. In the cycle after that, done_o and busy_o are both 0.
- R7: While busy_o is 1, including the done cycle, start_i and ring_set_i are ignored: no second window follows and ring_cmd_o stays 0.
- R8: ring_cmd_o only falls while shdn_pull_o is 1. The block has no output that can drive the shutdown line high.
- R9: When start_i and ring_set_i are high in the same idle cycle, start wins and ring_cmd_o is not set.
- R10: Changes on ring_period_i after the start request have no effect on the window length of the sequence that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| start_i | input | 1 | Request to begin the ringing-to-talk sequence |
| ring_set_i | input | 1 | Request to raise the ringing command while idle |
| ring_period_i | input | PER_W | Ringing period in clock cycles, sampled together with start |
| shdn_pull_o | output | 1 | Open-drain enable: 1 pulls the shutdown line low, 0 leaves it to the pull-up |
| ring_cmd_o | output | 1 | Ringing command to the switch device (1 = ringing, 0 = talk) |
| busy_o | output | 1 | Sequence in progress, including the done cycle |
| done_o | output | 1 | One-cycle pulse after the shutdown line is released |

## Verification
Most internal faults show up at the ports within one sequence. A state register that is stuck or wrong shows at once as a pull window whose length differs from L+1, or as a done pulse that is missing or lasts two cycles. A hold counter that loads or counts wrongly shows when the line is released. A misplaced clear strobe shows on the cycle ring_cmd_o falls: it is either not one cycle after the pull rises, or it is outside the window. Faults in the idle-gating logic only show when a request arrives while the block is busy: a second window follows, or the ringing command comes back a cycle later.

// File: rtl/bbm_seq_pkg.sv
`timescale 1ns/1ps
package bbm_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/bbm_rst_sync.sv
`timescale 1ns/1ps
module bbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[g] <= 1'b0;
          else         sync_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bbm_hold_timer.sv
`timescale 1ns/1ps
module bbm_hold_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  output logic             expired_o
);

  localparam logic [PER_W-1:0] MIN_HOLD = PER_W'(1);

  logic [PER_W-1:0] half_per;
  logic [PER_W-1:0] load_val;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Half period, never below one cycle, so the clear lands inside the window
  always_comb begin
    half_per = period_i >> 1;
    load_val = (half_per == '0) ? MIN_HOLD : half_per;
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - MIN_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/bbm_ctrl_fsm.sv
`timescale 1ns/1ps
module bbm_ctrl_fsm
  import bbm_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hold_expired_i,
  output logic load_o,
  output logic run_o,
  output logic clr_o,
  output logic pull_o,
  output logic busy_o,
  output logic done_o
);

  seq_state_t state_q, state_d;
  logic       first_q, first_d;

  always_comb begin
    state_d = state_q;
    first_d = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LOW;
          first_d = 1'b1;
          load_o  = 1'b1;
        end
      end
      ST_LOW: begin
        if (!first_q && hold_expired_i) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
    end
  end

  assign run_o  = (state_q == ST_LOW);
  assign clr_o  = (state_q == ST_LOW) && first_q;
  assign pull_o = (state_q == ST_LOW);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);

endmodule

// File: rtl/bbm_ring_cmd_reg.sv
`timescale 1ns/1ps
module bbm_ring_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic cmd_o
);

  logic cmd_q, cmd_d, cmd_en;

  // Clear has priority over set
  always_comb begin
    cmd_en = set_i | clr_i;
    cmd_d  = clr_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= 1'b0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;

endmodule

// File: rtl/bbm_rtt_seq.sv
`timescale 1ns/1ps
module bbm_rtt_seq #(
  parameter int PER_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             start_i,
  input  logic             ring_set_i,
  input  logic [PER_W-1:0] ring_period_i,
  output logic             shdn_pull_o,
  output logic             ring_cmd_o,
  output logic             busy_o,
  output logic             done_o
);

  logic rst_n_s;
  logic tmr_load, tmr_run, tmr_expired;
  logic cmd_clr, cmd_set;
  logic busy_w;

  bbm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_s)
  );

  bbm_hold_timer #(.PER_W(PER_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_i    (tmr_load),
    .run_i     (tmr_run),
    .period_i  (ring_period_i),
    .expired_o (tmr_expired)
  );

  bbm_ctrl_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .start_i        (start_i),
    .hold_expired_i (tmr_expired),
    .load_o         (tmr_load),
    .run_o          (tmr_run),
    .clr_o          (cmd_clr),
    .pull_o         (shdn_pull_o),
    .busy_o         (busy_w),
    .done_o         (done_o)
  );

  // Set accepted only when idle and no start competes for the same cycle
  assign cmd_set = ring_set_i & ~busy_w & ~start_i;

  bbm_ring_cmd_reg u_cmd (
    .clk   (clk),
    .rst_n (rst_n_s),
    .set_i (cmd_set),
    .clr_i (cmd_clr),
    .cmd_o (ring_cmd_o)
  );

  assign busy_o = busy_w;

endmodule

// File: rtl/bbm_rtt_seq_chk.sv
`timescale 1ns/1ps
module bbm_rtt_seq_chk #(
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             ring_set_i,
  input logic [PER_W-1:0] ring_period_i,
  input logic             shdn_pull_o,
  input logic             ring_cmd_o,
  input logic             busy_o,
  input logic             done_o
);

  logic [PER_W:0] win_len_q;
  logic [PER_W:0] exp_len_q;
  logic           pull_d;
  logic [PER_W-1:0] half_w;

  assign half_w = ring_period_i >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_len_q <= '0;
      exp_len_q <= '0;
      pull_d    <= 1'b0;
    end else begin
      pull_d <= shdn_pull_o;
      if (!busy_o && start_i)
        exp_len_q <= ((half_w == '0) ? (PER_W+1)'(1) : (PER_W+1)'(half_w)) + (PER_W+1)'(1);
      if (shdn_pull_o) win_len_q <= win_len_q + (PER_W+1)'(1);
      else             win_len_q <= '0;
      // R4 R10
      if (!shdn_pull_o && pull_d)
        window_len_chk: assert (win_len_q == exp_len_q)
          else $error("window length %0d expected %0d", win_len_q, exp_len_q);
    end
  end

  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (shdn_pull_o && busy_o));

  // R5
  clear_after_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shdn_pull_o) |=> !ring_cmd_o);

  // R8
  clear_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_cmd_o) |-> shdn_pull_o);

  // R6
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shdn_pull_o) |-> (done_o && busy_o));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R7
  ring_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_cmd_o) |-> $past(!busy_o && !start_i && ring_set_i));

  // R6
  pull_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shdn_pull_o, done_o}));

endmodule

bind bbm_rtt_seq bbm_rtt_seq_chk #(.PER_W(PER_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_s),
  .start_i       (start_i),
  .ring_set_i    (ring_set_i),
  .ring_period_i (ring_period_i),
  .shdn_pull_o   (shdn_pull_o),
  .ring_cmd_o    (ring_cmd_o),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/bbm_rtt_seq_tb.sv
`timescale 1ns/1ps
module bbm_rtt_seq_tb;

  localparam int PER_W = 16;

  typedef struct {
    int win_len;
    bit was_set;
  } exp_item_t;

  logic             clk;
  logic             arst_n;
  logic             start_i;
  logic             ring_set_i;
  logic [PER_W-1:0] ring_period_i;
  logic             shdn_pull_o;
  logic             ring_cmd_o;
  logic             busy_o;
  logic             done_o;

  int n_chk;
  int n_fail;
  int cyc;
  int rise_cyc;
  int clr_cyc;
  bit mon_on;
  bit pull_q, ring_q, done_q;
  bit ring_m;
  exp_item_t exp_q[$];

  bbm_rtt_seq #(.PER_W(PER_W)) u_dut (
    .clk           (clk),
    .arst_n        (arst_n),
    .start_i       (start_i),
    .ring_set_i    (ring_set_i),
    .ring_period_i (ring_period_i),
    .shdn_pull_o   (shdn_pull_o),
    .ring_cmd_o    (ring_cmd_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: pops scoreboard items as the pull windows close
  always @(negedge clk) begin
    exp_item_t it;
    cyc++;
    if (mon_on) begin
      if (shdn_pull_o && !pull_q) rise_cyc = cyc;
      if (!ring_cmd_o && ring_q) clr_cyc = cyc;
      if (done_q)
        chk(!done_o && !busy_o, "R6 done single cycle, busy drops", {done_o, busy_o}, 0);
      if (!shdn_pull_o && pull_q) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected pull window", cyc - rise_cyc, 0);
        end else begin
          it = exp_q.pop_front();
          chk((cyc - rise_cyc) == it.win_len, "R4 R10 window length", cyc - rise_cyc, it.win_len);
          if (it.was_set)
            chk((clr_cyc - rise_cyc) == 1, "R5 R8 clear one cycle after pull", clr_cyc - rise_cyc, 1);
          chk(ring_cmd_o == 1'b0, "R5 R7 ring command cleared", ring_cmd_o, 0);
          chk(done_o && busy_o, "R6 done and busy after release", {done_o, busy_o}, 3);
        end
      end
    end
    pull_q = shdn_pull_o;
    ring_q = ring_cmd_o;
    done_q = done_o;
  end

  task automatic set_ring();
    @(negedge clk);
    ring_set_i = 1'b1;
    @(negedge clk);
    ring_set_i = 1'b0;
    ring_m = 1'b1;
    chk(ring_cmd_o == 1'b1, "R2 ring command set", ring_cmd_o, 1);
  endtask

  // mode 0 plain, 1 requests mid-window, 2 period change, 3 start on done, 4 start+set together
  task automatic run_seq(input int per, input int mode);
    exp_item_t it;
    it.win_len = (((per / 2) < 1) ? 1 : (per / 2)) + 1;
    it.was_set = ring_m;
    exp_q.push_back(it);
    @(negedge clk);
    ring_period_i = PER_W'(per);
    start_i = 1'b1;
    if (mode == 4) ring_set_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ring_set_i = 1'b0;
    ring_m = 1'b0;
    chk(shdn_pull_o && busy_o, "R3 pull and busy after start", {shdn_pull_o, busy_o}, 3);
    if (mode == 4)
      chk(ring_cmd_o == 1'b0, "R9 start wins over set", ring_cmd_o, 0);
    if (mode == 1) begin
      @(negedge clk);
      start_i = 1'b1;
      ring_set_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      ring_set_i = 1'b0;
      chk(ring_cmd_o == 1'b0, "R7 set ignored while busy", ring_cmd_o, 0);
    end
    if (mode == 2) begin
      @(negedge clk);
      ring_period_i = PER_W'(2);
    end
    while (!done_o) @(negedge clk);
    if (mode == 3) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (mode == 3)
      chk(!shdn_pull_o && !busy_o, "R7 start in done cycle ignored", {shdn_pull_o, busy_o}, 0);
    @(negedge clk);
    chk(!shdn_pull_o && !busy_o && !ring_cmd_o, "R7 R9 no restart, talk state",
        {shdn_pull_o, busy_o, ring_cmd_o}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; mon_on = 1'b0; ring_m = 1'b0;
    arst_n = 1'b0; start_i = 1'b0; ring_set_i = 1'b0; ring_period_i = '0;
    repeat (3) @(negedge clk);
    chk({shdn_pull_o, ring_cmd_o, busy_o, done_o} == 4'b0, "R1 reset state",
        {shdn_pull_o, ring_cmd_o, busy_o, done_o}, 0);
    arst_n = 1'b1;
    @(negedge clk);
    chk({shdn_pull_o, ring_cmd_o, busy_o, done_o} == 4'b0, "R1 during reset release",
        {shdn_pull_o, ring_cmd_o, busy_o, done_o}, 0);
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    set_ring();
    run_seq(20, 0);
    set_ring();
    run_seq(7, 0);
    set_ring();
    run_seq(1, 0);
    set_ring();
    run_seq(0, 0);
    set_ring();
    run_seq(3, 0);
    set_ring();
    run_seq(20, 1);
    set_ring();
    run_seq(30, 2);
    set_ring();
    run_seq(6, 3);
    run_seq(10, 4);
    run_seq(4, 0);
    set_ring();
    run_seq(1000, 0);
    set_ring();
    run_seq(65535, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all windows seen", exp_q.size(), 0);
    chk(!shdn_pull_o && !busy_o && !done_o, "R6 idle at end", {shdn_pull_o, busy_o, done_o}, 0);
    report();
  end

endmodule